// File: doc/BRIEF.md
# Start-Bit Framed Command Receiver

This block is the device-facing half of a serial command port for a multichannel data converter. A host drives chip select low and clocks bits in, most significant first, on rising edges of a serial clock. The receiver discards any leading zeros. It treats the first one bit after select falls as the start of an 8-bit command. When the eighth bit has been taken, it decodes the command's fields onto parallel outputs.

The serial clock, chip select and data pins are asynchronous to the system clock. Each of them passes through a synchroniser, and serial clock edges are found in the system clock domain. After a complete command, the decoded fields are registered, and `cmd_valid` pulses for one system clock. The fields then hold until the next command completes. If select rises before the byte is finished, the partial byte is dropped. Once a command has been framed, further bits in the same select window have no effect.

Top module: `cmd_byte_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `cmd_valid` is 0 and every decoded output is 0.
- R2: After chip select falls, zero bits clocked before the first one bit are discarded, and that one bit becomes bit 7 of the command, whatever number of zeros came before it.
- R3: Bits are taken most significant first. The field layout is: bit 7 start, bits 6:4 select code (`cmd_sel`), bit 3 polarity, bit 2 input mode, bits 1:0 power/clock mode.
- R4: `cmd_unipolar` is 1 for unipolar and 0 for bipolar. `cmd_single` is 1 for single-ended and 0 for differential. Each is copied from its command bit.
- R5: `cmd_pwr` carries bits 1:0 unchanged, coded 00 full power-down, 01 fast power-down, 10 internal clock mode, 11 external clock mode.
- R6: `cmd_chan` maps the select code (bit6,bit5,bit4) as follows: 000→0, 100→1, 001→2, 101→3, 010→4, 110→5, 011→6, 111→7.
- R7: Each complete command gives exactly one `cmd_valid` pulse, one system clock wide.
- R8: Between commands, all decoded outputs hold their values.
- R9: If chip select rises before the eighth bit, the partial byte is dropped with no pulse, and the next window searches for a start bit afresh.
- R10: After a command completes, further serial clock edges in the same select window give no pulse and change no output.
- R11: Serial clock edges while chip select is high give no pulse and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| din | input | 1 | Serial data input |
| cmd_valid | output | 1 | One-cycle strobe when a command has been framed |
| cmd_sel | output | 3 | Raw select code, command bits 6:4 |
| cmd_chan | output | 3 | Mapped channel index |
| cmd_unipolar | output | 1 | 1 unipolar, 0 bipolar |
| cmd_single | output | 1 | 1 single-ended, 0 differential |
| cmd_pwr | output | 2 | Power/clock mode code |

## Verification
The assertions assume that the serial clock is much slower than the system clock. Each serial clock level must last several system clocks, so that every rising edge survives the synchroniser and no two command completions land in adjacent cycles. They also assume that `din` is stable around each serial clock rise. The stimulus holds every serial clock half-period for four system clocks. It changes `din` only while the serial clock is low, and it moves chip select only with the serial clock low and idle for several cycles.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int CMD_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    PWR_FULL_DOWN = 2'b00,
    PWR_FAST_DOWN = 2'b01,
    PWR_INT_CLK   = 2'b10,
    PWR_EXT_CLK   = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             unipolar;
    logic             single;
    pwr_mode_e        pwr;
  } cmd_fields_t;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              q_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_d <= RST_VAL;
    else     q_d <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~q_d;
  assign fall = ~q & q_d;
endmodule

// File: rtl/cmdrx_framer.sv
module cmdrx_framer #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_lvl,
  input  logic             sclk_rise,
  input  logic             din_lvl,
  output logic             byte_stb,
  output logic [CMD_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             done;
  logic [CMD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || cs_lvl) begin
      cnt      <= '0;
      done     <= 1'b0;
      shreg    <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (sclk_rise && !done) begin
        if (cnt == '0) begin
          if (din_lvl) begin
            shreg <= {{(CMD_W-1){1'b0}}, 1'b1};
            cnt   <= CNT_W'(1);
          end
        end else begin
          shreg <= {shreg[CMD_W-2:0], din_lvl};
          if (cnt == LAST) begin
            byte_stb <= 1'b1;
            done     <= 1'b1;
            cnt      <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign byte_q = shreg;
endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
  import cmdrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_stb,
  input  logic [CMD_W-1:0] byte_q,
  output logic             cmd_valid,
  output cmd_fields_t      fields,
  output logic [SEL_W-1:0] chan
);
  cmd_fields_t next_f;

  always_comb begin
    next_f.sel      = byte_q[CMD_W-2 -: SEL_W];
    next_f.unipolar = byte_q[3];
    next_f.single   = byte_q[2];
    next_f.pwr      = pwr_mode_e'(byte_q[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      fields    <= '0;
      chan      <= '0;
    end else begin
      cmd_valid <= byte_stb;
      if (byte_stb) begin
        fields <= next_f;
        // rotate: top select bit becomes channel LSB
        chan   <= {next_f.sel[SEL_W-2:0], next_f.sel[SEL_W-1]};
      end
    end
  end
endmodule

// File: rtl/cmd_byte_rx.sv
module cmd_byte_rx
  import cmdrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       din,
  output logic       cmd_valid,
  output logic [2:0] cmd_sel,
  output logic [2:0] cmd_chan,
  output logic       cmd_unipolar,
  output logic       cmd_single,
  output logic [1:0] cmd_pwr
);
  logic             cs_lvl, cs_rise_u, cs_fall_u;
  logic             sclk_lvl, sclk_rise, sclk_fall_u;
  logic             din_lvl, din_rise_u, din_fall_u;
  logic             byte_stb;
  logic [CMD_W-1:0] byte_q;
  cmd_fields_t      fields;
  logic [SEL_W-1:0] chan;

  cmdrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_lvl), .rise(cs_rise_u), .fall(cs_fall_u));
  cmdrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall_u));
  cmdrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_din (
    .clk(clk), .rst(rst), .d(din), .q(din_lvl), .rise(din_rise_u), .fall(din_fall_u));

  cmdrx_framer #(.CMD_W(CMD_W)) i_framer (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sclk_rise(sclk_rise),
    .din_lvl(din_lvl), .byte_stb(byte_stb), .byte_q(byte_q));

  cmdrx_decode i_decode (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_q(byte_q),
    .cmd_valid(cmd_valid), .fields(fields), .chan(chan));

  assign cmd_sel      = fields.sel;
  assign cmd_chan     = chan;
  assign cmd_unipolar = fields.unipolar;
  assign cmd_single   = fields.single;
  assign cmd_pwr      = fields.pwr;
endmodule

// File: rtl/cmd_byte_rx_chk.sv
module cmd_byte_rx_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_sel,
  input logic [2:0] cmd_chan,
  input logic       cmd_unipolar,
  input logic       cmd_single,
  input logic [1:0] cmd_pwr
);
  localparam int QUIET = SYNC_STAGES + 4;
  localparam int QW    = $clog2(QUIET + 2);

  logic [QW-1:0] cs_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !cs_n)                cs_hi_cnt <= '0;
    else if (cs_hi_cnt != QW'(QUIET)) cs_hi_cnt <= cs_hi_cnt + QW'(1);
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && cmd_sel == 3'd0 && cmd_chan == 3'd0 &&
             !cmd_unipolar && !cmd_single && cmd_pwr == 2'd0));

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> ($stable(cmd_sel) && $stable(cmd_chan) && $stable(cmd_unipolar) &&
                    $stable(cmd_single) && $stable(cmd_pwr)));

  p_chan_map_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_chan == {cmd_sel[1:0], cmd_sel[2]}));

  p_cs_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt == QW'(QUIET)) |-> !cmd_valid);
endmodule

bind cmd_byte_rx cmd_byte_rx_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
  .cmd_chan(cmd_chan), .cmd_unipolar(cmd_unipolar), .cmd_single(cmd_single),
  .cmd_pwr(cmd_pwr));

// File: tb/test_cmd_byte_rx.sv
`timescale 1ns/1ps
module test_cmd_byte_rx;
  localparam int HALF  = 4;
  localparam int NVEC  = 8;
  localparam int LIMIT = 100000;

  // {leading zero count[3:0], command byte[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 8'b1000_1111}, {4'd3, 8'b1100_1110}, {4'd1, 8'b1001_0101},
    {4'd5, 8'b1101_1000}, {4'd2, 8'b1010_0011}, {4'd7, 8'b1110_1110},
    {4'd0, 8'b1011_0001}, {4'd9, 8'b1111_1100}};

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, din = 0;
  logic cmd_valid, cmd_unipolar, cmd_single;
  logic [2:0] cmd_sel, cmd_chan;
  logic [1:0] cmd_pwr;

  int checks = 0, fails = 0, pulses = 0, wide = 0, cycles = 0;
  logic prev_v = 0;
  logic [10:0] seen = '0;

  always #5 clk = ~clk;

  cmd_byte_rx i_cmd_byte_rx (.*);

  always @(negedge clk) begin
    if (cmd_valid) begin
      pulses++;
      seen = {cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr};
    end
    if (cmd_valid && prev_v) wide++;
    prev_v = cmd_valid;
  end

  function automatic logic [2:0] map_chan(input logic [2:0] s);
    case (s)
      3'b000: return 3'd0; 3'b100: return 3'd1; 3'b001: return 3'd2; 3'b101: return 3'd3;
      3'b010: return 3'd4; 3'b110: return 3'd5; 3'b011: return 3'd6; default: return 3'd7;
    endcase
  endfunction

  function automatic logic [10:0] expect_of(input logic [7:0] b);
    return {b[6:4], map_chan(b[6:4]), b[3], b[2], b[1:0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    din = b;
    tick(HALF); sclk = 1;
    tick(HALF); sclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cs_low();  cs_n = 0; tick(8); endtask
  task automatic cs_high(); tick(8); cs_n = 1; tick(12); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [10:0] last;
    tick(5);
    // R1: reset state
    check("R1 valid in reset", {31'd0, cmd_valid}, 0);
    check("R1 fields in reset", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, 0);
    rst = 0; tick(3);
    check("R1 after reset", {20'd0, cmd_valid, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, 0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      base = pulses;
      cs_low();
      for (int z = 0; z < int'(VEC[v][11:8]); z++) send_bit(1'b0);
      send_byte(VEC[v][7:0]);
      cs_high();
      check("R7 one pulse per command", pulses - base, 1);
      check("R2 R3 R4 R5 R6 decoded fields", {21'd0, seen}, {21'd0, expect_of(VEC[v][7:0])});
    end
    check("R7 pulse width", wide, 0);

    // R8: outputs hold after command
    last = expect_of(VEC[NVEC-1][7:0]);
    tick(40);
    check("R8 hold", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, {21'd0, last});

    // R11: clocking while deselected
    base = pulses;
    for (int i = 0; i < 12; i++) send_bit(i[0] ^ 1'b1);
    tick(12);
    check("R11 no pulse while deselected", pulses - base, 0);
    check("R11 fields unchanged", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, {21'd0, last});

    // R9: partial byte aborted
    base = pulses;
    cs_low();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    cs_high();
    check("R9 no pulse on partial", pulses - base, 0);
    check("R9 fields unchanged", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, {21'd0, last});
    cs_low();
    send_bit(1'b0); send_bit(1'b0);
    send_byte(8'b1001_1010);
    cs_high();
    check("R9 restart pulse", pulses - base, 1);
    check("R9 restart fields", {21'd0, seen}, {21'd0, expect_of(8'b1001_1010)});

    // R10: trailing bits after completion ignored
    base = pulses;
    cs_low();
    send_byte(8'b1110_0101);
    send_byte(8'b1111_1111);
    send_byte(8'b1000_0000);
    cs_high();
    check("R10 single pulse", pulses - base, 1);
    check("R10 first command kept", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr},
          {21'd0, expect_of(8'b1110_0101)});
    check("R7 pulse width overall", wide, 0);

    // R2: all-zero window never frames
    base = pulses;
    cs_low();
    for (int i = 0; i < 20; i++) send_bit(1'b0);
    cs_high();
    check("R2 zeros only", pulses - base, 0);

    // R1: reset mid-stream clears outputs
    rst = 1; tick(2); rst = 0; tick(1);
    check("R1 reset clears", {21'd0, cmd_sel, cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule